// File: doc/BRIEF.md
# Scanline Sprite Selector

This block walks a 32-entry sprite attribute table once per video line and picks the sprites that cover the line about to be drawn. At most four are kept, in table order. Each scan step is started by a one-cycle strobe from the line sequencer. The block then reads the Y byte of the current entry through a byte-wide read port and decides whether that entry is on the line. It also decides whether the entry terminates the table, or whether it is a fifth hit that must be reported as an overflow.

The read port is a valid/ready request stream with a response strobe. The block raises `req_valid` together with `req_addr` and holds both unchanged until a cycle in which `req_ready` is high. It then waits for `rsp_valid`, which must come in a later cycle, and takes `rsp_data` in that cycle. The block always accepts a response, so the response side has no ready signal. A strobe that arrives while a read is outstanding, or after the scan has finished, is dropped. `line_start` may be pulsed only between reads. It resets the scan position and the hit count, and it abandons any request that has not yet been accepted.

The selected indices appear on `sel_list`, with slot k in bits [5k+4:5k]. `last_idx` holds the index of the most recent entry that was examined and not kept. `ovf_flag` reports that a fifth sprite was found, and it stays set until software reads the status.

Top module: `spr_line_scan`

## Requirements
- R1: Each read address is the 7-bit table base in bits [13:7], the 5-bit entry index in bits [6:2], and zero in bits [1:0].
- R2: A request stays asserted with a stable address until accepted; one accepted strobe produces exactly one read, and strobes arriving while a read is outstanding are ignored.
- R3: An entry is on the line when (vcount + 1 − Y) taken modulo 256 is less than the sprite height.
- R4: The sprite height is 8 lines, doubled when `size_dbl` is 1 and doubled again when `mag_dbl` is 1 (8, 16 or 32).
- R5: On-line entries fill slots 0 to 3 in ascending index order, and `sel_count` counts every on-line entry found, up to 5.
- R6: A Y byte of 208 ends the scan at once: nothing is selected from it, `last_idx` becomes 32 and no further reads are issued on that line.
- R7: The scan reads no more than 32 entries, and it issues no read after a fifth on-line entry is found.
- R8: A fifth on-line entry sets `ovf_flag`, makes `sel_count` 5, and writes that entry's index into `last_idx`.
- R9: Each examined entry that is not selected writes its index into `last_idx`; `last_idx` never exceeds 32.
- R10: `ovf_flag` remains set across lines until a `status_clr` pulse clears it.
- R11: After reset, `sel_count`, `last_idx`, `ovf_flag` and `req_valid` are 0, and a `line_start` pulse returns `sel_count` and the scan index to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | Pulse that starts a new line scan |
| scan_strobe | input | 1 | One-cycle trigger for one scan step |
| tbl_base | input | 7 | Attribute table base (address bits 13:7) |
| size_dbl | input | 1 | Doubles sprite height |
| mag_dbl | input | 1 | Doubles sprite height again |
| vcount | input | 8 | Current line counter |
| status_clr | input | 1 | Status-read pulse that clears the overflow flag |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 14 | Read byte address |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 8 | Read data byte |
| sel_count | output | 3 | On-line entries found this line (0 to 5) |
| sel_list | output | 20 | Four 5-bit selected indices |
| last_idx | output | 6 | Last examined, unselected index (32 = end marker) |
| ovf_flag | output | 1 | Fifth-sprite overflow status |

## Verification
The hardest situations to reach are a fifth hit and a 208 end marker arriving mid-table, in each case followed by further strobes that must produce no reads. A close second is a request that is held by back-pressure while more strobes arrive. The stimulus builds the Y column of the table from a few generator patterns, each seeded so that hits land at chosen indices and with chosen modular wrap. Every line is over-strobed past 32 steps. On selected lines, `req_ready` toggles every cycle so that requests are held, and the number of accepted reads is compared with the number of entries the scan should examine.

// File: rtl/spr_scan_pkg.sv
package spr_scan_pkg;
  typedef enum logic [1:0] {
    SCAN_IDLE,
    SCAN_REQ,
    SCAN_WAIT
  } scan_state_e;
endpackage

// File: rtl/spr_line_match.sv
module spr_line_match #(
  parameter int unsigned Y_W        = 8,
  parameter int unsigned BASE_LINES = 8,
  parameter int unsigned END_Y      = 208
) (
  input  logic [Y_W-1:0] vcount,
  input  logic [Y_W-1:0] y_byte,
  input  logic           size_dbl,
  input  logic           mag_dbl,
  output logic           on_line,
  output logic           end_mark
);
  logic [Y_W-1:0] diff;
  logic [Y_W:0]   height;

  // modular distance from the sprite top to the next line
  assign diff = vcount + Y_W'(1) - y_byte;

  always_comb begin
    height = (Y_W+1)'(BASE_LINES);
    if (size_dbl) height = height << 1;
    if (mag_dbl)  height = height << 1;
  end

  assign on_line  = ({1'b0, diff} < height);
  assign end_mark = (y_byte == Y_W'(END_Y));
endmodule

// File: rtl/spr_slot_list.sv
module spr_slot_list #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned MAX_SEL = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(MAX_SEL+2)-1:0] wr_slot,
  input  logic [IDX_W:0]           wr_val,
  output logic [MAX_SEL*IDX_W-1:0] sel_list,
  output logic [IDX_W:0]           last_idx
);
  localparam int unsigned CNT_W = $clog2(MAX_SEL+2);

  for (genvar g = 0; g < MAX_SEL; g++) begin : g_slot
    logic [IDX_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                 slot_q <= '0;
      else if (wr_en && wr_slot == CNT_W'(g))     slot_q <= wr_val[IDX_W-1:0];
    end
    assign sel_list[g*IDX_W +: IDX_W] = slot_q;
  end

  // the spill slot: last unselected entry, a fifth hit, or the end marker
  logic [IDX_W:0] spill_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                                    spill_q <= '0;
    else if (wr_en && wr_slot == CNT_W'(MAX_SEL))  spill_q <= wr_val;
  end
  assign last_idx = spill_q;
endmodule

// File: rtl/spr_scan_ctrl.sv
module spr_scan_ctrl
  import spr_scan_pkg::*;
#(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned MAX_SEL = 4,
  parameter int unsigned BASE_W  = 7
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_start,
  input  logic                          scan_strobe,
  input  logic                          status_clr,
  input  logic [BASE_W-1:0]             tbl_base,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [BASE_W+IDX_W+1:0]       req_addr,
  input  logic                          rsp_valid,
  input  logic                          on_line,
  input  logic                          end_mark,
  output logic                          wr_en,
  output logic [$clog2(MAX_SEL+2)-1:0]  wr_slot,
  output logic [IDX_W:0]                wr_val,
  output logic [$clog2(MAX_SEL+2)-1:0]  sel_count,
  output logic                          ovf_flag
);
  localparam int unsigned POS_W = IDX_W + 1;
  localparam int unsigned CNT_W = $clog2(MAX_SEL+2);
  localparam logic [POS_W-1:0] IDX_END  = POS_W'(1 << IDX_W);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_SEL + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_SEL);

  scan_state_e       state_q;
  logic [POS_W-1:0]  idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              ovf_q;
  logic              scan_done;
  logic              eval;
  logic              hit;

  assign scan_done = (cnt_q == CNT_FULL) || (idx_q == IDX_END);
  assign eval      = (state_q == SCAN_WAIT) && rsp_valid && !line_start;
  assign hit       = eval && !end_mark && on_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
    end else begin
      unique case (state_q)
        SCAN_IDLE: if (!line_start && scan_strobe && !scan_done) state_q <= SCAN_REQ;
        SCAN_REQ:  if (line_start) state_q <= SCAN_IDLE;
                   else if (req_ready) state_q <= SCAN_WAIT;
        SCAN_WAIT: if (line_start || rsp_valid) state_q <= SCAN_IDLE;
        default:   state_q <= SCAN_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || line_start) begin
      idx_q <= '0;
      cnt_q <= '0;
    end else if (eval) begin
      idx_q <= end_mark ? IDX_END : idx_q + POS_W'(1);
      if (hit) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        ovf_q <= 1'b0;
    else if (hit && cnt_q == CNT_LAST) ovf_q <= 1'b1;
    else if (status_clr)               ovf_q <= 1'b0;
  end

  always_comb begin
    wr_en   = eval;
    wr_slot = CNT_LAST;
    wr_val  = idx_q;
    if (end_mark)     wr_val  = IDX_END;
    else if (on_line) wr_slot = cnt_q;
  end

  assign req_valid = (state_q == SCAN_REQ);
  assign req_addr  = {tbl_base, idx_q[IDX_W-1:0], 2'b00};
  assign sel_count = cnt_q;
  assign ovf_flag  = ovf_q;
endmodule

// File: rtl/spr_line_scan.sv
module spr_line_scan #(
  parameter int unsigned IDX_W      = 5,
  parameter int unsigned MAX_SEL    = 4,
  parameter int unsigned BASE_W     = 7,
  parameter int unsigned Y_W        = 8,
  parameter int unsigned BASE_LINES = 8,
  parameter int unsigned END_Y      = 208
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_start,
  input  logic                          scan_strobe,
  input  logic [BASE_W-1:0]             tbl_base,
  input  logic                          size_dbl,
  input  logic                          mag_dbl,
  input  logic [Y_W-1:0]                vcount,
  input  logic                          status_clr,
  output logic                          req_valid,
  input  logic                          req_ready,
  output logic [BASE_W+IDX_W+1:0]       req_addr,
  input  logic                          rsp_valid,
  input  logic [Y_W-1:0]                rsp_data,
  output logic [$clog2(MAX_SEL+2)-1:0]  sel_count,
  output logic [MAX_SEL*IDX_W-1:0]      sel_list,
  output logic [IDX_W:0]                last_idx,
  output logic                          ovf_flag
);
  localparam int unsigned CNT_W = $clog2(MAX_SEL+2);

  logic              on_line;
  logic              end_mark;
  logic              wr_en;
  logic [CNT_W-1:0]  wr_slot;
  logic [IDX_W:0]    wr_val;

  spr_line_match #(.Y_W(Y_W), .BASE_LINES(BASE_LINES), .END_Y(END_Y)) u_match (
    .vcount  (vcount),
    .y_byte  (rsp_data),
    .size_dbl(size_dbl),
    .mag_dbl (mag_dbl),
    .on_line (on_line),
    .end_mark(end_mark)
  );

  spr_scan_ctrl #(.IDX_W(IDX_W), .MAX_SEL(MAX_SEL), .BASE_W(BASE_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .scan_strobe(scan_strobe),
    .status_clr (status_clr),
    .tbl_base   (tbl_base),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .on_line    (on_line),
    .end_mark   (end_mark),
    .wr_en      (wr_en),
    .wr_slot    (wr_slot),
    .wr_val     (wr_val),
    .sel_count  (sel_count),
    .ovf_flag   (ovf_flag)
  );

  spr_slot_list #(.IDX_W(IDX_W), .MAX_SEL(MAX_SEL)) u_slots (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_slot (wr_slot),
    .wr_val  (wr_val),
    .sel_list(sel_list),
    .last_idx(last_idx)
  );
endmodule

// File: rtl/spr_scan_chk.sv
module spr_scan_chk #(
  parameter int unsigned IDX_W   = 5,
  parameter int unsigned MAX_SEL = 4,
  parameter int unsigned BASE_W  = 7
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          line_start,
  input logic                          status_clr,
  input logic [BASE_W-1:0]             tbl_base,
  input logic                          req_valid,
  input logic                          req_ready,
  input logic [BASE_W+IDX_W+1:0]       req_addr,
  input logic [$clog2(MAX_SEL+2)-1:0]  sel_count,
  input logic [IDX_W:0]                last_idx,
  input logic                          ovf_flag
);
  localparam int unsigned CNT_W = $clog2(MAX_SEL+2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(MAX_SEL + 1);

  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_addr[1:0] == 2'b00) && (req_addr[BASE_W+IDX_W+1:IDX_W+2] == tbl_base));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready && !line_start |=> req_valid && $stable(req_addr));

  p_cnt_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> (sel_count == $past(sel_count)) || (sel_count == $past(sel_count) + CNT_W'(1)));

  p_cnt_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_count <= CNT_FULL);

  p_no_req_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_count == CNT_FULL) && !req_valid && !line_start |=> !req_valid);

  p_ovf_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> sel_count == CNT_FULL);

  p_last_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    last_idx <= (IDX_W+1)'(1 << IDX_W));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !status_clr |=> ovf_flag);

  p_line_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> sel_count == '0);
endmodule

bind spr_line_scan spr_scan_chk #(.IDX_W(IDX_W), .MAX_SEL(MAX_SEL), .BASE_W(BASE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_start(line_start),
  .status_clr(status_clr),
  .tbl_base  (tbl_base),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .sel_count (sel_count),
  .last_idx  (last_idx),
  .ovf_flag  (ovf_flag)
);

// File: tb/tb_spr_line_scan.sv
module tb_spr_line_scan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        line_start = 1'b0;
  logic        scan_strobe = 1'b0;
  logic [6:0]  tbl_base = '0;
  logic        size_dbl = 1'b0;
  logic        mag_dbl = 1'b0;
  logic [7:0]  vcount = '0;
  logic        status_clr = 1'b0;
  logic        req_valid;
  logic        req_ready;
  logic [13:0] req_addr;
  logic        rsp_valid;
  logic [7:0]  rsp_data;
  logic [2:0]  sel_count;
  logic [19:0] sel_list;
  logic [5:0]  last_idx;
  logic        ovf_flag;

  always #5 clk = ~clk;

  spr_line_scan dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .scan_strobe(scan_strobe),
    .tbl_base(tbl_base), .size_dbl(size_dbl), .mag_dbl(mag_dbl), .vcount(vcount),
    .status_clr(status_clr), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sel_count(sel_count), .sel_list(sel_list), .last_idx(last_idx), .ovf_flag(ovf_flag)
  );

  int tests_run = 0;
  int tests_failed = 0;
  int cyc = 0;

  // memory model with optional back-pressure
  logic [7:0] ymem [32];
  logic stall = 1'b0;
  logic mem_ready;
  int   rd_cnt = 0;
  int   addr_err = 0;
  assign req_ready = mem_ready;

  always @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      mem_ready <= 1'b1;
    end else begin
      mem_ready <= stall ? ~mem_ready : 1'b1;
      rsp_valid <= req_valid && mem_ready;
      rsp_data  <= ymem[req_addr[6:2]];
      if (req_valid && mem_ready) begin
        rd_cnt <= rd_cnt + 1;
        if (req_addr[13:7] != tbl_base || req_addr[1:0] != 2'b00) addr_err <= addr_err + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      tests_failed = tests_failed + 1;
      $display("FAIL watchdog: run hung (act %0d exp <150000 cycles)", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests_run + 1, tests_failed);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests_run = tests_run + 1;
    if (!ok) begin
      tests_failed = tests_failed + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ygen(input logic [2:0] pat, input logic [7:0] seed, input int i);
    case (pat)
      3'd0:    ygen = seed + 8'(7 * i);
      3'd1:    ygen = seed;
      3'd2:    ygen = (i == int'(seed)) ? 8'd208 : 8'd100;
      3'd3:    ygen = seed - 8'(i);
      default: ygen = seed ^ 8'(i);
    endcase
  endfunction

  // expected state carried across lines
  int exp_last = 0;
  bit exp_ovf = 1'b0;

  task automatic run_case(input logic [7:0] v, input bit s, input bit m, input bit stl,
                          input bit clr, input string tag);
    int cnt = 0;
    int lst [4] = '{0, 0, 0, 0};
    int reads = 0;
    int hgt;
    int rd0;
    logic [7:0] d;
    hgt = 8 << (int'(s) + int'(m));
    for (int i = 0; i < 32 && cnt < 5; i++) begin
      reads++;
      if (ymem[i] == 8'd208) begin exp_last = 32; break; end
      d = v + 8'd1 - ymem[i];
      if (int'(d) < hgt) begin
        if (cnt < 4) lst[cnt] = i; else exp_last = i;
        cnt++;
      end else exp_last = i;
    end
    if (clr) exp_ovf = 1'b0;
    if (cnt == 5) exp_ovf = 1'b1;
    @(negedge clk);
    vcount = v; size_dbl = s; mag_dbl = m; stall = stl;
    status_clr = clr; line_start = 1'b1;
    @(negedge clk);
    status_clr = 1'b0; line_start = 1'b0;
    rd0 = rd_cnt;
    for (int k = 0; k < 34; k++) begin
      scan_strobe = 1'b1;
      @(negedge clk);
      scan_strobe = 1'b0;
      repeat (8) @(negedge clk);
    end
    chk(int'(sel_count) == cnt, {tag, " R5 count"}, int'(sel_count), cnt);
    for (int k = 0; k < 4; k++)
      if (k < cnt) chk(int'(sel_list[k*5 +: 5]) == lst[k], {tag, " R3/R4 slot"}, int'(sel_list[k*5 +: 5]), lst[k]);
    chk(int'(last_idx) == exp_last, {tag, " R9 last index"}, int'(last_idx), exp_last);
    chk(ovf_flag == exp_ovf, {tag, " R8 overflow"}, int'(ovf_flag), int'(exp_ovf));
    chk(rd_cnt - rd0 == reads, {tag, " R7 read count"}, rd_cnt - rd0, reads);
  endtask

  // {vcount[21:14], size[13], mag[12], pattern[11:9], seed[8:1], stall[0]}
  localparam logic [21:0] VECS [10] = '{
    {8'd10,  1'b0, 1'b0, 3'd1, 8'd8,   1'b0},
    {8'd10,  1'b0, 1'b0, 3'd1, 8'd12,  1'b0},
    {8'd50,  1'b1, 1'b0, 3'd0, 8'd30,  1'b1},
    {8'd50,  1'b0, 1'b1, 3'd0, 8'd30,  1'b0},
    {8'd50,  1'b1, 1'b1, 3'd0, 8'd30,  1'b1},
    {8'd50,  1'b0, 1'b0, 3'd0, 8'd30,  1'b0},
    {8'd200, 1'b0, 1'b0, 3'd2, 8'd5,   1'b0},
    {8'd99,  1'b0, 1'b0, 3'd2, 8'd2,   1'b1},
    {8'd255, 1'b0, 1'b0, 3'd3, 8'd3,   1'b1},
    {8'd20,  1'b1, 1'b1, 3'd4, 8'd7,   1'b0}
  };

  initial begin
    for (int i = 0; i < 32; i++) ymem[i] = 8'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    chk(sel_count == 3'd0, "R11 reset count", int'(sel_count), 0);
    chk(last_idx == 6'd0, "R11 reset last", int'(last_idx), 0);
    chk(!ovf_flag, "R11 reset overflow", int'(ovf_flag), 0);
    chk(!req_valid, "R11 reset request", int'(req_valid), 0);

    for (int n = 0; n < 10; n++) begin
      tbl_base = 7'(n * 13 + 3);
      for (int i = 0; i < 32; i++) ymem[i] = ygen(VECS[n][11:9], VECS[n][8:1], i);
      run_case(VECS[n][21:14], VECS[n][13], VECS[n][12], VECS[n][0], 1'b1, "vec");
    end

    // R6: end marker at entry 0
    for (int i = 0; i < 32; i++) ymem[i] = ygen(3'd2, 8'd0, i);
    run_case(8'd99, 1'b0, 1'b0, 1'b0, 1'b1, "R6 end at first");
    chk(last_idx == 6'd32, "R6 last index is 32", int'(last_idx), 32);

    // R10: overflow held across a line with no hits, then cleared
    for (int i = 0; i < 32; i++) ymem[i] = 8'd9;
    run_case(8'd10, 1'b0, 1'b0, 1'b0, 1'b1, "R8 overflow line");
    for (int i = 0; i < 32; i++) ymem[i] = 8'd150;
    run_case(8'd10, 1'b0, 1'b0, 1'b1, 1'b0, "R10 sticky line");
    chk(ovf_flag, "R10 flag still set", int'(ovf_flag), 1);
    @(negedge clk); status_clr = 1'b1;
    @(negedge clk); status_clr = 1'b0;
    chk(!ovf_flag, "R10 cleared by status read", int'(ovf_flag), 0);

    // R11: line_start clears the hit count
    for (int i = 0; i < 32; i++) ymem[i] = 8'd9;
    run_case(8'd10, 1'b1, 1'b0, 1'b0, 1'b1, "R11 prep");
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    chk(sel_count == 3'd0, "R11 line_start clears count", int'(sel_count), 0);

    // R2: back-to-back strobes under back-pressure give one read
    begin
      int r0;
      for (int i = 0; i < 32; i++) ymem[i] = 8'd100;
      vcount = 8'd200; stall = 1'b1;
      @(negedge clk); line_start = 1'b1;
      @(negedge clk); line_start = 1'b0;
      r0 = rd_cnt;
      scan_strobe = 1'b1;
      repeat (3) @(negedge clk);
      scan_strobe = 1'b0;
      repeat (10) @(negedge clk);
      chk(rd_cnt - r0 == 1, "R2 strobes while busy ignored", rd_cnt - r0, 1);
      chk(last_idx == 6'd0, "R9 entry 0 examined", int'(last_idx), 0);
    end

    chk(addr_err == 0, "R1 address layout", addr_err, 0);

    $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end
endmodule